// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block moves a small system between run mode and two reduced-power modes when software asks for them. A light mode stops only the processor clock and leaves every peripheral clocked, so any peripheral can raise the interrupt that ends it. A deep mode shuts the system down in a fixed one-step-per-cycle order. It drops the PLL connection, turns the PLL off and stops all clocks while pulsing a reset into the CPU and USB clock dividers. It then parks the flash in standby and powers the main oscillator down. The internal RC oscillator stays powered with only its output blocked, so it is ready at once when the system wakes.

A wake event is any set bit of the pending-interrupt vector or the RTC interrupt. It ends the deep mode through a reverse sequence. The main oscillator powers up first and a parameterised settling count runs. Then the clocks and RC output come back, the flash leaves standby, and the block returns to run. The PLL stays off until software enables it again. The block also holds a per-peripheral clock gating register that software writes while in run mode. A 2-bit status output shows the current mode.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset, the outputs are as follows. coreClkEn, mainOscPwr, rcOutEn and rcPwr are 1. pllEn, pllConn, flashStandby and divReset are 0. periphClkEn equals PERIPH_RST (all ones by default). modeStatus is 00, which means run.
- R2: In run mode, a request for the light mode on reqIdle stops the processor clock at the same edge that samples the request. modeStatus becomes 01, which means idle. periphClkEn, mainOscPwr and rcOutEn are unchanged.
- R3: In idle, any set bit of irqPending or a high rtcIrq sets coreClkEn to 1 and modeStatus to 00 at the next edge. Without such an event, idle is held.
- R4: A request for the deep mode on reqSleep sets modeStatus to 10 at the edge that samples it. At each of the following edges, one step takes place, in this order: (1) pllConn goes to 0. (2) pllEn goes to 0. (3) coreClkEn, rcOutEn and every periphClkEn bit go to 0, and divReset is high for exactly one cycle. (4) flashStandby goes to 1. (5) mainOscPwr goes to 0.
- R5: rcPwr stays 1 in every mode, including sleep.
- R6: In sleep, a wake event (a set bit of irqPending, or rtcIrq) sets modeStatus to 11, which means waking, at the next edge. mainOscPwr rises one edge later. After that edge, STAB_CYCLES more edges pass with the clocks still off. At the next edge, coreClkEn, rcOutEn and periphClkEn are restored. At the edge after that, flashStandby is cleared and modeStatus returns to 00.
- R7: pllEn stays 0 after a wake until a write on pllEnWr sets it. A write on pllConnWr is ignored while pllEn is 0. Clearing pllEn also clears pllConn.
- R8: When reqIdle and reqSleep are sampled together in run mode, the sleep sequence is taken and the idle request is discarded.
- R9: A request that arrives outside run mode is held and taken at the first edge after the return to run. A request is cleared when its mode is entered, so the mode is not re-entered without a new request.
- R10: In run mode, a write on gateWrEn loads gateWrData into the gating register, and periphClkEn then equals it (bit i gates peripheral i). A write outside run mode is ignored. The register value is kept through idle and through sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqIdle | input | 1 | Request to enter the light (idle) mode |
| reqSleep | input | 1 | Request to enter the deep (sleep) mode |
| irqPending | input | NUM_IRQ | Enabled pending interrupts; any set bit is a wake event |
| rtcIrq | input | 1 | RTC interrupt, a wake event |
| gateWrEn | input | 1 | Write strobe for the peripheral clock gating register |
| gateWrData | input | NUM_PERIPH | Gating value, one enable bit per peripheral |
| pllEnWr | input | 1 | Write strobe for the PLL enable |
| pllEnVal | input | 1 | Value written to the PLL enable |
| pllConnWr | input | 1 | Write strobe for the PLL connect |
| pllConnVal | input | 1 | Value written to the PLL connect |
| coreClkEn | output | 1 | Processor clock enable |
| periphClkEn | output | NUM_PERIPH | Per-peripheral clock enables |
| mainOscPwr | output | 1 | Main oscillator power |
| rcOutEn | output | 1 | Internal RC oscillator output enable |
| rcPwr | output | 1 | Internal RC oscillator power |
| pllEn | output | 1 | PLL enable |
| pllConn | output | 1 | PLL connected as the clock source |
| flashStandby | output | 1 | Flash standby request |
| divReset | output | 1 | One-cycle reset of the CPU and USB clock dividers |
| modeStatus | output | 2 | Current mode: 00 run, 01 idle, 10 sleep, 11 waking |

## Verification
The light mode is tried once with an interrupt-vector wake and once with an RTC wake. This shows whether both sources reach the idle exit, and whether idle holds when no event is present. The deep mode is walked through cycle by cycle with the PLL first enabled and connected, so that each shutdown step can be seen against the one before it. The wake sequence is then timed edge by edge to tell an early clock restore from a correct settling count. Further patterns are a simultaneous request for both modes, a request made while waking, and gating and PLL writes made with the PLL off or outside run mode. These show the priority, the request latching and the write filtering.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  // Mode status encoding seen on modeStatus
  localparam logic [1:0] MODE_RUN    = 2'b00;
  localparam logic [1:0] MODE_IDLE   = 2'b01;
  localparam logic [1:0] MODE_SLEEP  = 2'b10;
  localparam logic [1:0] MODE_WAKING = 2'b11;

  typedef enum logic [3:0] {
    ST_RUN,
    ST_IDLE,
    ST_PLL_DISC,
    ST_PLL_OFF,
    ST_GATE,
    ST_FLASH_SBY,
    ST_OSC_OFF,
    ST_SLEEP,
    ST_OSC_ON,
    ST_STAB,
    ST_CLK_ON,
    ST_FLASH_WAKE
  } lpm_state_e;

  // Strobes from control to datapath, at most a few per cycle
  typedef struct packed {
    logic coreOff;
    logic coreOn;
    logic pllDisc;
    logic pllOff;
    logic clkGate;
    logic flashSby;
    logic oscOff;
    logic oscOn;
    logic cntLoad;
    logic cntDec;
    logic clkOn;
    logic flashWake;
    logic swWrEn;
  } lpm_strobe_t;

  function automatic logic [1:0] stateToMode(lpm_state_e s);
    case (s)
      ST_RUN:                      return MODE_RUN;
      ST_IDLE:                     return MODE_IDLE;
      ST_PLL_DISC, ST_PLL_OFF, ST_GATE, ST_FLASH_SBY, ST_OSC_OFF, ST_SLEEP:
                                   return MODE_SLEEP;
      default:                     return MODE_WAKING;
    endcase
  endfunction

endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqIdle,
  input  logic               reqSleep,
  input  logic [NUM_IRQ-1:0] irqPending,
  input  logic               rtcIrq,
  input  logic               stabDone,
  output lpm_strobe_t        stb,
  output logic [1:0]         modeStatus
);

  lpm_state_e state, stateNxt;
  logic pendIdle, pendSleep;
  logic wantIdle, wantSleep, wakeEvt;
  logic takeSleep, takeIdle;

  assign wantIdle  = pendIdle | reqIdle;
  assign wantSleep = pendSleep | reqSleep;
  assign wakeEvt   = (|irqPending) | rtcIrq;
  assign takeSleep = (state == ST_RUN) && wantSleep;
  assign takeIdle  = (state == ST_RUN) && !wantSleep && wantIdle;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    unique case (state)
      ST_RUN: begin
        stb.swWrEn = 1'b1;
        if (takeSleep) begin
          stateNxt = ST_PLL_DISC;
        end else if (takeIdle) begin
          stb.coreOff = 1'b1;
          stateNxt    = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (wakeEvt) begin
          stb.coreOn = 1'b1;
          stateNxt   = ST_RUN;
        end
      end
      ST_PLL_DISC: begin
        stb.pllDisc = 1'b1;
        stateNxt    = ST_PLL_OFF;
      end
      ST_PLL_OFF: begin
        stb.pllOff = 1'b1;
        stateNxt   = ST_GATE;
      end
      ST_GATE: begin
        stb.clkGate = 1'b1;
        stateNxt    = ST_FLASH_SBY;
      end
      ST_FLASH_SBY: begin
        stb.flashSby = 1'b1;
        stateNxt     = ST_OSC_OFF;
      end
      ST_OSC_OFF: begin
        stb.oscOff = 1'b1;
        stateNxt   = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (wakeEvt) stateNxt = ST_OSC_ON;
      end
      ST_OSC_ON: begin
        stb.oscOn   = 1'b1;
        stb.cntLoad = 1'b1;
        stateNxt    = ST_STAB;
      end
      ST_STAB: begin
        if (stabDone) stateNxt = ST_CLK_ON;
        else          stb.cntDec = 1'b1;
      end
      ST_CLK_ON: begin
        stb.clkOn = 1'b1;
        stateNxt  = ST_FLASH_WAKE;
      end
      ST_FLASH_WAKE: begin
        stb.flashWake = 1'b1;
        stateNxt      = ST_RUN;
      end
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_RUN;
      pendIdle  <= 1'b0;
      pendSleep <= 1'b0;
    end else begin
      state <= stateNxt;
      // Sleep entry discards both requests; idle entry clears its own
      pendSleep <= takeSleep ? 1'b0 : wantSleep;
      pendIdle  <= (takeSleep || takeIdle) ? 1'b0 : wantIdle;
    end
  end

  assign modeStatus = stateToMode(state);

endmodule

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int                    NUM_PERIPH  = 8,
  parameter int                    STAB_CYCLES = 5,
  parameter logic [NUM_PERIPH-1:0] PERIPH_RST  = '1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  lpm_strobe_t           stb,
  input  logic                  gateWrEn,
  input  logic [NUM_PERIPH-1:0] gateWrData,
  input  logic                  pllEnWr,
  input  logic                  pllEnVal,
  input  logic                  pllConnWr,
  input  logic                  pllConnVal,
  output logic                  stabDone,
  output logic                  coreClkEn,
  output logic [NUM_PERIPH-1:0] periphClkEn,
  output logic                  mainOscPwr,
  output logic                  rcOutEn,
  output logic                  pllEn,
  output logic                  pllConn,
  output logic                  flashStandby,
  output logic                  divReset
);

  localparam int CW = (STAB_CYCLES < 2) ? 1 : $clog2(STAB_CYCLES);
  localparam logic [CW-1:0] CNT_INIT = CW'(STAB_CYCLES - 1);

  logic [NUM_PERIPH-1:0] gateReg;
  logic                  allClkOn;
  logic [CW-1:0]         stabCnt;

  // Clock enables, oscillator and flash controls
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreClkEn    <= 1'b1;
      allClkOn     <= 1'b1;
      rcOutEn      <= 1'b1;
      mainOscPwr   <= 1'b1;
      flashStandby <= 1'b0;
      divReset     <= 1'b0;
    end else begin
      divReset <= stb.clkGate;
      if (stb.coreOff) coreClkEn <= 1'b0;
      if (stb.coreOn)  coreClkEn <= 1'b1;
      if (stb.clkGate) begin
        coreClkEn <= 1'b0;
        allClkOn  <= 1'b0;
        rcOutEn   <= 1'b0;
      end
      if (stb.clkOn) begin
        coreClkEn <= 1'b1;
        allClkOn  <= 1'b1;
        rcOutEn   <= 1'b1;
      end
      if (stb.flashSby)  flashStandby <= 1'b1;
      if (stb.flashWake) flashStandby <= 1'b0;
      if (stb.oscOff)    mainOscPwr   <= 1'b0;
      if (stb.oscOn)     mainOscPwr   <= 1'b1;
    end
  end

  // PLL control: sequencer forces it off, software turns it back on
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pllEn   <= 1'b0;
      pllConn <= 1'b0;
    end else begin
      if (stb.swWrEn && pllConnWr && pllEn) pllConn <= pllConnVal;
      if (stb.swWrEn && pllEnWr) begin
        pllEn <= pllEnVal;
        if (!pllEnVal) pllConn <= 1'b0;
      end
      if (stb.pllDisc) pllConn <= 1'b0;
      if (stb.pllOff)  pllEn   <= 1'b0;
    end
  end

  // Oscillator settling counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            stabCnt <= '0;
    else if (stb.cntLoad) stabCnt <= CNT_INIT;
    else if (stb.cntDec)  stabCnt <= stabCnt - CW'(1);
  end
  assign stabDone = (stabCnt == '0);

  // Per-peripheral gating register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      gateReg <= PERIPH_RST;
    else if (stb.swWrEn && gateWrEn) gateReg <= gateWrData;
  end

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_gate
    assign periphClkEn[i] = gateReg[i] & allClkOn;
  end

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int                    NUM_PERIPH  = 8,
  parameter int                    NUM_IRQ     = 4,
  parameter int                    STAB_CYCLES = 5,
  parameter logic [NUM_PERIPH-1:0] PERIPH_RST  = '1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqIdle,
  input  logic                  reqSleep,
  input  logic [NUM_IRQ-1:0]    irqPending,
  input  logic                  rtcIrq,
  input  logic                  gateWrEn,
  input  logic [NUM_PERIPH-1:0] gateWrData,
  input  logic                  pllEnWr,
  input  logic                  pllEnVal,
  input  logic                  pllConnWr,
  input  logic                  pllConnVal,
  output logic                  coreClkEn,
  output logic [NUM_PERIPH-1:0] periphClkEn,
  output logic                  mainOscPwr,
  output logic                  rcOutEn,
  output logic                  rcPwr,
  output logic                  pllEn,
  output logic                  pllConn,
  output logic                  flashStandby,
  output logic                  divReset,
  output logic [1:0]            modeStatus
);

  lpm_strobe_t stb;
  logic        stabDone;

  lpm_ctrl #(.NUM_IRQ(NUM_IRQ)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqIdle    (reqIdle),
    .reqSleep   (reqSleep),
    .irqPending (irqPending),
    .rtcIrq     (rtcIrq),
    .stabDone   (stabDone),
    .stb        (stb),
    .modeStatus (modeStatus)
  );

  lpm_datapath #(
    .NUM_PERIPH  (NUM_PERIPH),
    .STAB_CYCLES (STAB_CYCLES),
    .PERIPH_RST  (PERIPH_RST)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .gateWrEn     (gateWrEn),
    .gateWrData   (gateWrData),
    .pllEnWr      (pllEnWr),
    .pllEnVal     (pllEnVal),
    .pllConnWr    (pllConnWr),
    .pllConnVal   (pllConnVal),
    .stabDone     (stabDone),
    .coreClkEn    (coreClkEn),
    .periphClkEn  (periphClkEn),
    .mainOscPwr   (mainOscPwr),
    .rcOutEn      (rcOutEn),
    .pllEn        (pllEn),
    .pllConn      (pllConn),
    .flashStandby (flashStandby),
    .divReset     (divReset)
  );

  // RC oscillator is never powered down by this block; only its output is gated
  assign rcPwr = 1'b1;

endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk
  import lpm_pkg::*;
#(
  parameter int NUM_PERIPH = 8,
  parameter int NUM_IRQ    = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_IRQ-1:0]    irqPending,
  input logic                  rtcIrq,
  input logic                  coreClkEn,
  input logic [NUM_PERIPH-1:0] periphClkEn,
  input logic                  mainOscPwr,
  input logic                  rcOutEn,
  input logic                  pllEn,
  input logic                  pllConn,
  input logic                  flashStandby,
  input logic                  divReset,
  input logic [1:0]            modeStatus
);

  assert_run_clean_R1: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == MODE_RUN) |-> (mainOscPwr && !flashStandby));

  assert_idle_core_only_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == MODE_IDLE) |-> (!coreClkEn && mainOscPwr && rcOutEn));

  assert_idle_exit_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((modeStatus == MODE_IDLE) && ((|irqPending) || rtcIrq)) |=>
      ((modeStatus == MODE_RUN) && coreClkEn));

  assert_osc_off_last_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mainOscPwr) |-> (flashStandby && !coreClkEn && !pllEn));

  assert_flash_after_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashStandby) |-> (!coreClkEn && !rcOutEn && !pllEn && !pllConn));

  assert_div_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    divReset |=> !divReset);

  assert_sleep_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((modeStatus == MODE_SLEEP) && flashStandby) |-> (periphClkEn == '0));

  assert_osc_on_waking_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mainOscPwr) |-> (modeStatus == MODE_WAKING));

  assert_rc_after_osc_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rcOutEn) |-> mainOscPwr);

  assert_flash_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flashStandby) |-> (coreClkEn && rcOutEn && mainOscPwr));

  assert_conn_needs_pll_R7: assert property (@(posedge clk) disable iff (!rstN)
    pllConn |-> pllEn);

endmodule

bind lpm_sequencer lpm_sequencer_chk #(
  .NUM_PERIPH (NUM_PERIPH),
  .NUM_IRQ    (NUM_IRQ)
) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .irqPending   (irqPending),
  .rtcIrq       (rtcIrq),
  .coreClkEn    (coreClkEn),
  .periphClkEn  (periphClkEn),
  .mainOscPwr   (mainOscPwr),
  .rcOutEn      (rcOutEn),
  .pllEn        (pllEn),
  .pllConn      (pllConn),
  .flashStandby (flashStandby),
  .divReset     (divReset),
  .modeStatus   (modeStatus)
);

// File: tb/sim_lpm_sequencer.sv
`timescale 1ns/1ps
module sim_lpm_sequencer;

  localparam int NP   = 8;
  localparam int NI   = 4;
  localparam int STAB = 5;

  logic          clk = 1'b0;
  logic          rstN;
  logic          reqIdle, reqSleep, rtcIrq;
  logic [NI-1:0] irqPending;
  logic          gateWrEn;
  logic [NP-1:0] gateWrData;
  logic          pllEnWr, pllEnVal, pllConnWr, pllConnVal;
  logic          coreClkEn, mainOscPwr, rcOutEn, rcPwr, pllEn, pllConn;
  logic          flashStandby, divReset;
  logic [NP-1:0] periphClkEn;
  logic [1:0]    modeStatus;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lpm_sequencer #(.NUM_PERIPH(NP), .NUM_IRQ(NI), .STAB_CYCLES(STAB)) u0 (
    .clk(clk), .rstN(rstN), .reqIdle(reqIdle), .reqSleep(reqSleep),
    .irqPending(irqPending), .rtcIrq(rtcIrq), .gateWrEn(gateWrEn),
    .gateWrData(gateWrData), .pllEnWr(pllEnWr), .pllEnVal(pllEnVal),
    .pllConnWr(pllConnWr), .pllConnVal(pllConnVal), .coreClkEn(coreClkEn),
    .periphClkEn(periphClkEn), .mainOscPwr(mainOscPwr), .rcOutEn(rcOutEn),
    .rcPwr(rcPwr), .pllEn(pllEn), .pllConn(pllConn),
    .flashStandby(flashStandby), .divReset(divReset), .modeStatus(modeStatus)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Advance n rising edges, then sit 1 ns past the edge
  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic enterSleepQuiet();
    reqSleep = 1'b1; step(1); reqSleep = 1'b0;
    step(5);
  endtask

  task automatic t_reset();
    check("R1", "coreClkEn", coreClkEn, 1);
    check("R1", "mainOscPwr", mainOscPwr, 1);
    check("R1", "rcOutEn", rcOutEn, 1);
    check("R1", "pllEn", pllEn, 0);
    check("R1", "pllConn", pllConn, 0);
    check("R1", "flashStandby", flashStandby, 0);
    check("R1", "divReset", divReset, 0);
    check("R1", "periphClkEn", periphClkEn, 8'hFF);
    check("R1", "modeStatus", modeStatus, 0);
    check("R5", "rcPwr at reset", rcPwr, 1);
  endtask

  task automatic t_gate_write();
    gateWrEn = 1'b1; gateWrData = 8'hA5; step(1); gateWrEn = 1'b0;
    check("R10", "periphClkEn after write", periphClkEn, 8'hA5);
  endtask

  task automatic t_idle_irq();
    reqIdle = 1'b1; step(1); reqIdle = 1'b0;
    check("R2", "coreClkEn in idle", coreClkEn, 0);
    check("R2", "modeStatus idle", modeStatus, 1);
    check("R2", "periphClkEn kept in idle", periphClkEn, 8'hA5);
    check("R2", "mainOscPwr in idle", mainOscPwr, 1);
    step(3);
    check("R3", "idle held without wake", modeStatus, 1);
    irqPending = 4'b0100; step(1); irqPending = '0;
    check("R3", "coreClkEn after irq", coreClkEn, 1);
    check("R3", "modeStatus after irq", modeStatus, 0);
    step(4);
    check("R9", "no idle re-entry", modeStatus, 0);
  endtask

  task automatic t_idle_rtc();
    reqIdle = 1'b1; step(1); reqIdle = 1'b0;
    check("R2", "idle via second request", modeStatus, 1);
    rtcIrq = 1'b1; step(1); rtcIrq = 1'b0;
    check("R3", "coreClkEn after rtc", coreClkEn, 1);
    check("R3", "modeStatus after rtc", modeStatus, 0);
  endtask

  task automatic t_pll_sw();
    pllConnWr = 1'b1; pllConnVal = 1'b1; step(1); pllConnWr = 1'b0;
    check("R7", "connect ignored with pll off", pllConn, 0);
    pllEnWr = 1'b1; pllEnVal = 1'b1; step(1); pllEnWr = 1'b0;
    pllConnWr = 1'b1; step(1); pllConnWr = 1'b0;
    check("R7", "pllEn set by write", pllEn, 1);
    check("R7", "pllConn set by write", pllConn, 1);
  endtask

  task automatic t_sleep_cycle();
    reqSleep = 1'b1; step(1); reqSleep = 1'b0;
    check("R4", "status sleep at request edge", modeStatus, 2);
    check("R4", "pllConn before step 1", pllConn, 1);
    step(1);
    check("R4", "step1 pllConn", pllConn, 0);
    check("R4", "step1 pllEn still on", pllEn, 1);
    step(1);
    check("R4", "step2 pllEn", pllEn, 0);
    check("R4", "step2 core still on", coreClkEn, 1);
    step(1);
    check("R4", "step3 coreClkEn", coreClkEn, 0);
    check("R4", "step3 rcOutEn", rcOutEn, 0);
    check("R4", "step3 periphClkEn", periphClkEn, 0);
    check("R4", "step3 divReset", divReset, 1);
    check("R4", "step3 flash not yet", flashStandby, 0);
    step(1);
    check("R4", "step4 flashStandby", flashStandby, 1);
    check("R4", "step4 divReset dropped", divReset, 0);
    check("R4", "step4 osc still on", mainOscPwr, 1);
    step(1);
    check("R4", "step5 mainOscPwr", mainOscPwr, 0);
    check("R5", "rcPwr in sleep", rcPwr, 1);
    step(3);
    check("R4", "sleep held", modeStatus, 2);
    gateWrEn = 1'b1; gateWrData = 8'h00; step(1); gateWrEn = 1'b0;
    rtcIrq = 1'b1; step(1); rtcIrq = 1'b0;
    check("R6", "status waking", modeStatus, 3);
    check("R6", "osc off at wake edge", mainOscPwr, 0);
    step(1);
    check("R6", "osc powered first", mainOscPwr, 1);
    check("R6", "core off while settling", coreClkEn, 0);
    step(STAB);
    check("R6", "core off at end of settling", coreClkEn, 0);
    step(1);
    check("R6", "core restored", coreClkEn, 1);
    check("R6", "rc output restored", rcOutEn, 1);
    check("R10", "gate value kept, sleep write ignored", periphClkEn, 8'hA5);
    check("R6", "flash still standby", flashStandby, 1);
    step(1);
    check("R6", "flash released", flashStandby, 0);
    check("R6", "status run", modeStatus, 0);
    check("R7", "pllEn stays off after wake", pllEn, 0);
    check("R7", "pllConn stays off after wake", pllConn, 0);
  endtask

  task automatic t_both_requests();
    reqIdle = 1'b1; reqSleep = 1'b1; step(1);
    reqIdle = 1'b0; reqSleep = 1'b0;
    check("R8", "sleep wins", modeStatus, 2);
    step(5);
    check("R8", "osc down in sleep", mainOscPwr, 0);
    irqPending = 4'b1000; step(1); irqPending = '0;
    check("R6", "irq vector wakes sleep", modeStatus, 3);
    step(STAB + 3);
    check("R6", "run after irq wake", modeStatus, 0);
    step(3);
    check("R8", "idle request discarded", modeStatus, 0);
  endtask

  task automatic t_req_latched();
    enterSleepQuiet();
    check("R9", "in sleep before wake", modeStatus, 2);
    rtcIrq = 1'b1; step(1); rtcIrq = 1'b0;
    reqIdle = 1'b1; step(1); reqIdle = 1'b0;
    step(STAB + 2);
    check("R9", "run reached", modeStatus, 0);
    check("R9", "core on at return", coreClkEn, 1);
    step(1);
    check("R9", "held idle request taken", modeStatus, 1);
    irqPending = 4'b0001; step(1); irqPending = '0;
    step(3);
    check("R9", "request cleared after entry", modeStatus, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqIdle = 1'b0; reqSleep = 1'b0; rtcIrq = 1'b0;
    irqPending = '0; gateWrEn = 1'b0; gateWrData = '0;
    pllEnWr = 1'b0; pllEnVal = 1'b0; pllConnWr = 1'b0; pllConnVal = 1'b0;
    step(3);
    t_reset();
    rstN = 1'b1;
    step(2);
    t_reset();
    t_gate_write();
    t_idle_irq();
    t_idle_rtc();
    t_pll_sw();
    t_sleep_cycle();
    t_both_requests();
    t_req_latched();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule